// File: doc/BRIEF.md
# Write-Protected Watchdog Timer

The block is a watchdog that counts ticks of a slow timebase. A software loop keeps rewriting its control register, and each accepted write restarts the count. If the loop stops doing this, the count reaches a programmed limit. The block then either requests a system reset or raises an interrupt, and in both cases it sets a sticky status flag. A four-bit prescale field sets the limit to 512 × 2^n ticks for codes 0 to 7. At the usual 32.768 kHz tick rate this gives timeouts from about 15.6 ms up to 2 s. Code 8 requests a reset at once.

Writes to the control register are guarded by an unlock sequence. A write with bit 0 set only arms the register and changes nothing else. The next write, and only that one, is applied, and applying it disarms the register again. A write that arrives while the register is not armed, and that does not itself arm it, is dropped. Only writes count as accesses, and idle cycles between the two writes do not cancel the arming. The register port is plain: a write strobe, write data and read data that is always valid. It has no handshake and never stalls.

Top module: `wdt_guard`

## Requirements
- R1: After reset the read value is 8'h00: prescale 0, interrupt mode off, flag clear, watchdog disabled, not armed. `sys_rst_req`, `irq` and `wd_flag` are low.
- R2: The read value is {prescale[7:4], response[3], flag[2], enable[1], armed[0]}. A write with bit 0 = 1 while not armed sets armed and leaves all other fields unchanged.
- R3: A write while armed is accepted and clears armed. The accepted write loads prescale from bits 7:4, response from bit 3 and enable from bit 1.
- R4: A write while not armed with bit 0 = 0 is ignored and leaves the read value unchanged.
- R5: When enabled with prescale n (0 to 7) and a tick on every cycle, the timeout occurs on the 512·2^n-th tick after the accepted write, and `wd_flag` then reads 1.
- R6: With response 0 a timeout drives `sys_rst_req` high for exactly one cycle. With response 1 it raises `irq` and leaves `sys_rst_req` low.
- R7: Prescale code 8 with enable = 1 raises `sys_rst_req` in the cycle after the accepted write, whatever the response bit is.
- R8: An accepted write with prescale code 9 to 15 keeps the previous prescale and still applies the response and enable bits.
- R9: Every accepted write restarts the count from zero.
- R10: With enable = 0 the count does not run, and no reset or flag is produced.
- R11: The count advances only on cycles where `tick` is high.
- R12: An accepted write with bit 2 = 0 clears the flag. `irq` equals flag AND response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase enable pulse, one per timebase period |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| sys_rst_req | output | 1 | System reset request, one cycle per timeout |
| irq | output | 1 | Timeout interrupt, level |
| wd_flag | output | 1 | Sticky timeout status |

## Verification
The bench samples the exact boundary tick for codes 0 and 1, one cycle before the timeout and on it. An off-by-one limit or a wrong shift would move the reset by a cycle or by a factor of two. Unarmed writes and writes with reserved codes are read back afterwards. A design that skipped the unlock would take the unarmed write, and one that stored code 9 to 15 would lose the old timeout. A refresh half way through the count, and a tick at half rate, show whether the count restarts and whether it obeys the tick gating. A counter that ignores either would fire early.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PRESC_W   = 4;
  localparam int SHIFT_MAX = 7;
  localparam logic [PRESC_W-1:0] IMM_CODE = 4'd8;

  typedef struct packed {
    logic [PRESC_W-1:0] presc;
    logic               resp;
    logic               flag;
    logic               en;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_key,
  output logic armed,
  output logic accept
);
  logic arm_set;

  assign accept  = wr_en & armed;
  assign arm_set = wr_en & ~armed & wr_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (accept)  armed <= 1'b0;
    else if (arm_set) armed <= 1'b1;
  end

  // R2
  arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed && wr_key) |=> armed);
  // R3
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && armed) |=> !armed);
endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [7:1] wr_fields,
  input  logic       timeout,
  output wdt_cfg_t   cfg
);
  logic [PRESC_W-1:0] new_presc;
  logic               presc_ok;

  assign new_presc = wr_fields[7:4];
  assign presc_ok  = new_presc <= IMM_CODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (accept) begin
        if (presc_ok) cfg.presc <= new_presc;
        cfg.resp <= wr_fields[3];
        cfg.en   <= wr_fields[1];
      end
      if (timeout)     cfg.flag <= 1'b1;
      else if (accept) cfg.flag <= cfg.flag & wr_fields[2];
    end
  end

  // R8
  reserved_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_fields[7:4] > IMM_CODE) |=> $stable(cfg.presc));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE = 512,
  parameter int CW   = 17
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc,
  output logic               expire,
  output logic               imm
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign imm    = presc == IMM_CODE;
  assign limit  = CW'(BASE) << presc[2:0];
  assign expire = run & (imm | (tick & (cnt == limit - 1'b1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (restart | ~run | expire)   cnt <= '0;
    else if (tick)                      cnt <= cnt + 1'b1;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !imm) |-> cnt < limit);
  // R11
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart && !expire) |=> $stable(cnt));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int BASE = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sys_rst_req,
  output logic       irq,
  output logic       wd_flag
);
  localparam int CW = $clog2(BASE) + SHIFT_MAX + 1;

  logic     armed, accept, expire, imm;
  wdt_cfg_t cfg;

  wdt_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_key(wr_data[0]),
    .armed(armed), .accept(accept)
  );

  wdt_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .accept(accept), .wr_fields(wr_data[7:1]),
    .timeout(expire), .cfg(cfg)
  );

  wdt_counter #(.BASE(BASE), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(cfg.en), .restart(accept),
    .presc(cfg.presc), .expire(expire), .imm(imm)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_rst_req <= 1'b0;
    else        sys_rst_req <= expire & (imm | ~cfg.resp);
  end

  assign rd_data = {cfg.presc, cfg.resp, cfg.flag, cfg.en, armed};
  assign irq     = cfg.flag & cfg.resp;
  assign wd_flag = cfg.flag;

  // R4
  unarmed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed && !wr_data[0]) |=> $stable({cfg.presc, cfg.resp, cfg.en}));
  // R10
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |=> !sys_rst_req);
  // R6
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.resp && !imm) |=> !sys_rst_req);
  // R5
  rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> wd_flag);
endmodule

// File: tb/sim_wdt_guard.sv
`timescale 1ns/1ps
module sim_wdt_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       half = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sys_rst_req, irq, wd_flag;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  wdt_guard u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sys_rst_req(sys_rst_req), .irq(irq), .wd_flag(wd_flag)
  );

  always #2 clk = ~clk;

  always @(negedge clk) tick <= half ? ~tick : 1'b1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    half = 1'b0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  task automatic prot(input logic [7:0] d);
    wr(8'h01);
    wr(d);
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 rd", rd_data, 8'h00);
    check("R1 rst", sys_rst_req, 0);
    check("R1 irq/flag", {irq, wd_flag}, 0);
  endtask

  task automatic t_unlock();
    do_reset();
    wr(8'h01);
    check("R2 armed", rd_data, 8'h01);
    wr(8'h32);
    check("R3 applied", rd_data, 8'h32);
  endtask

  task automatic t_ignore();
    do_reset();
    wr(8'h72);
    check("R4 dropped", rd_data, 8'h00);
    wait_edges(600);
    check("R10 no reset", {sys_rst_req, wd_flag}, 0);
  endtask

  task automatic t_code0_reset();
    do_reset();
    prot(8'h02);
    wait_edges(511);
    check("R5 early", sys_rst_req, 0);
    wait_edges(1);
    check("R6 rst", sys_rst_req, 1);
    check("R5 flag", wd_flag, 1);
    wait_edges(1);
    check("R6 pulse", sys_rst_req, 0);
  endtask

  task automatic t_code1_irq();
    do_reset();
    prot(8'h1A);
    wait_edges(1023);
    check("R5 early irq", irq, 0);
    wait_edges(1);
    check("R6 irq", irq, 1);
    check("R6 no rst", sys_rst_req, 0);
    prot(8'h1A);
    check("R12 cleared", {irq, wd_flag}, 0);
    check("R12 rd", rd_data, 8'h1A);
  endtask

  task automatic t_imm();
    do_reset();
    prot(8'h8A);
    check("R7 not yet", sys_rst_req, 0);
    wait_edges(1);
    check("R7 imm", sys_rst_req, 1);
  endtask

  task automatic t_reserved();
    do_reset();
    prot(8'h22);
    prot(8'hFA);
    check("R8 keep", rd_data, 8'h2A);
  endtask

  task automatic t_restart();
    do_reset();
    prot(8'h02);
    wait_edges(400);
    prot(8'h02);
    wait_edges(511);
    check("R9 restarted", sys_rst_req, 0);
    wait_edges(1);
    check("R9 fire", sys_rst_req, 1);
  endtask

  task automatic t_half_tick();
    int seen = -1;
    do_reset();
    half = 1'b1;
    prot(8'h02);
    for (int i = 1; i <= 1100; i++) begin
      @(negedge clk);
      if (sys_rst_req && seen < 0) seen = i;
    end
    half = 1'b0;
    check("R11 window", (seen >= 1000 && seen <= 1040), 1);
  endtask

  initial begin
    t_reset();
    t_unlock();
    t_ignore();
    t_code0_reset();
    t_code1_irq();
    t_imm();
    t_reserved();
    t_restart();
    t_half_tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule